// File: doc/BRIEF.md
# Exponential Backoff Pause Unit

This block gives one hardware thread a way to step aside when its atomic operations keep losing to other threads. A retry register holds a backoff weight that starts at 1. Each time the thread reports a failed attempt, the unit turns the current weight into a stall request of weight × 2^SCALE_SH cycles and starts a pause. The weight then doubles, until it has grown past a ceiling. A success or clear pulse returns the weight to 1.

The pause itself runs on a coarse timer. The requested cycle count is divided by 2^TICK_SH, and the quotient is loaded into a counter. A prescaler, restarted at every load, steps the counter down once every 2^TICK_SH cycles. A request too small to yield a single tick still costs one cycle. The same timer can be loaded directly with a cycle count through a write port. A trap input cuts a running pause short.

While the pause runs, `busy_o` is high and `stall_o` holds the thread. `done_o` pulses once when the pause is over. With the defaults (SCALE_SH=7, TICK_SH=3, LIMIT=4096), one weight unit is 128 cycles, counted as 16 ticks of 8.

Top module: `backoff_pause_unit`

## Requirements
- R1: After reset `busy_o`, `stall_o` and `done_o` are 0, and the backoff weight is 1, so the first accepted fail stalls for 2^SCALE_SH cycles (128 with the defaults).
- R2: A `fail_i` pulse that is accepted (the unit is idle and `clear_i` is low) starts a stall of weight × 2^SCALE_SH cycles. If the weight is not above LIMIT, it then doubles.
- R3: Once the weight is above LIMIT, further fails leave it unchanged. With LIMIT=16 the stalls run 128, 256, 512, 1024, 2048, 4096, 4096 cycles.
- R4: `clear_i` returns the weight to 1. A `fail_i` in the same cycle as `clear_i` is dropped and starts no stall.
- R5: An accepted `wr_valid_i` with an amount A ≥ 2^TICK_SH stalls for (A >> TICK_SH) × 2^TICK_SH cycles. The low TICK_SH bits are discarded, so with the defaults 100 gives 96 cycles.
- R6: A written amount below 2^TICK_SH (0 to 7 with the defaults) stalls for exactly 1 cycle.
- R7: `fail_i` and `wr_valid_i` are ignored while `busy_o` is high. They neither reload the pause nor change the weight.
- R8: `trap_i` while `busy_o` is high drops `stall_o` in the same cycle, and `busy_o` is low from the next cycle. `trap_i` while idle has no effect.
- R9: `done_o` is high for exactly one cycle: the first cycle after `busy_o` falls, whether the pause ran out or a trap ended it.
- R10: `busy_o` is high in every stalled cycle. `stall_o` equals `busy_o` except in a cycle where `trap_i` is high.
- R11: When `fail_i` and `wr_valid_i` are both accepted in the same idle cycle, the fail wins: the stall is weight × 2^SCALE_SH cycles and the written amount is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fail_i | input | 1 | Atomic attempt failed; request a backoff pause |
| clear_i | input | 1 | Attempt succeeded; return the weight to 1 |
| trap_i | input | 1 | Disrupting event; aborts a running pause |
| wr_valid_i | input | 1 | Direct pause write strobe |
| wr_amount_i | input | BO_W+SCALE_SH | Requested pause in cycles |
| stall_o | output | 1 | Hold the thread this cycle |
| busy_o | output | 1 | A pause is running |
| done_o | output | 1 | One-cycle pulse after a pause ends |

## Verification
The checker assumes that every input is synchronous to `clk_i` and settled at the rising edge. It also assumes that a pause can only start from `fail_i` or `wr_valid_i`, and that `trap_i` carries no meaning outside a pause.

The bench drives all inputs on the falling edge and holds each strobe for exactly one cycle. It raises `trap_i` only for a single cycle, either mid-pause or while idle, so the abort rule and the idle-trap rule are each exercised on their own. Stall lengths are measured by counting falling edges on which `busy_o` is high.

// File: rtl/bo_pkg.sv
package bo_pkg;
  localparam int unsigned DEF_LIMIT    = 4096;
  localparam int unsigned DEF_SCALE_SH = 7;
  localparam int unsigned DEF_TICK_SH  = 3;
endpackage

// File: rtl/bo_weight.sv
module bo_weight #(
  parameter int unsigned LIMIT = bo_pkg::DEF_LIMIT,
  parameter int unsigned BO_W  = $clog2(LIMIT) + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_i,
  input  logic            clear_i,
  output logic [BO_W-1:0] bo_o
);
  localparam logic [BO_W-1:0] LIM = BO_W'(LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   bo_o <= BO_W'(1);
    else if (clear_i)              bo_o <= BO_W'(1);
    else if (step_i && bo_o <= LIM) bo_o <= bo_o << 1;
  end
endmodule

// File: rtl/bo_pause_ctr.sv
module bo_pause_ctr #(
  parameter int unsigned AMT_W   = 21,
  parameter int unsigned TICK_SH = bo_pkg::DEF_TICK_SH,
  localparam int unsigned CNT_W  = AMT_W - TICK_SH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             trap_i,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [AMT_W-1:0] ONE_TICK = AMT_W'(1) << TICK_SH;

  logic [CNT_W-1:0]   cnt_q;
  logic [TICK_SH-1:0] pre_q;

  assign busy_o = |cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pre_q  <= '0;
      done_o <= 1'b0;
    end else if (load_i) begin
      done_o <= 1'b0;
      if (amt_i < ONE_TICK) begin
        // sub-tick request: one tick that expires after a single cycle
        cnt_q <= CNT_W'(1);
        pre_q <= '1;
      end else begin
        cnt_q <= CNT_W'(amt_i >> TICK_SH);
        pre_q <= '0;
      end
    end else if (busy_o && trap_i) begin
      cnt_q  <= '0;
      pre_q  <= '0;
      done_o <= 1'b1;
    end else if (busy_o) begin
      pre_q <= pre_q + 1'b1;
      if (&pre_q) begin
        cnt_q  <= cnt_q - 1'b1;
        done_o <= (cnt_q == CNT_W'(1));
      end else begin
        done_o <= 1'b0;
      end
    end else begin
      done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/backoff_pause_unit.sv
module backoff_pause_unit #(
  parameter int unsigned LIMIT    = bo_pkg::DEF_LIMIT,
  parameter int unsigned SCALE_SH = bo_pkg::DEF_SCALE_SH,
  parameter int unsigned TICK_SH  = bo_pkg::DEF_TICK_SH,
  localparam int unsigned BO_W    = $clog2(LIMIT) + 2,
  localparam int unsigned AMT_W   = BO_W + SCALE_SH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fail_i,
  input  logic             clear_i,
  input  logic             trap_i,
  input  logic             wr_valid_i,
  input  logic [AMT_W-1:0] wr_amount_i,
  output logic             stall_o,
  output logic             busy_o,
  output logic             done_o
);
  logic [BO_W-1:0]  bo;
  logic             take_fail, take_wr, load;
  logic [AMT_W-1:0] req_amt, load_amt;

  assign take_fail = fail_i & ~clear_i & ~busy_o;
  assign take_wr   = wr_valid_i & ~busy_o & ~take_fail;
  assign load      = take_fail | take_wr;
  assign req_amt   = AMT_W'(bo) << SCALE_SH;
  assign load_amt  = take_fail ? req_amt : wr_amount_i;
  assign stall_o   = busy_o & ~trap_i;

  bo_weight #(.LIMIT(LIMIT), .BO_W(BO_W)) u_weight (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (take_fail),
    .clear_i (clear_i),
    .bo_o    (bo)
  );

  bo_pause_ctr #(.AMT_W(AMT_W), .TICK_SH(TICK_SH)) u_pause (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .amt_i  (load_amt),
    .trap_i (trap_i),
    .busy_o (busy_o),
    .done_o (done_o)
  );
endmodule

// File: rtl/bo_pause_chk.sv
module bo_pause_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic fail_i,
  input logic wr_valid_i,
  input logic trap_i,
  input logic stall_o,
  input logic busy_o,
  input logic done_o
);
  // R10
  stall_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> busy_o);
  // R8
  trap_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && trap_i) |=> (!busy_o && done_o));
  // R9
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));
  // R9
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(fail_i || wr_valid_i));
  // R5
  wr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && wr_valid_i) |=> busy_o);
endmodule

bind backoff_pause_unit bo_pause_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fail_i     (fail_i),
  .wr_valid_i (wr_valid_i),
  .trap_i     (trap_i),
  .stall_o    (stall_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/tb_backoff_pause_unit.sv
`timescale 1ns/1ps
module tb_backoff_pause_unit;
  localparam int unsigned LIMIT    = 16;
  localparam int unsigned SCALE_SH = 7;
  localparam int unsigned TICK_SH  = 3;
  localparam int unsigned AMT_W    = $clog2(LIMIT) + 2 + SCALE_SH;
  localparam int NV = 8;
  localparam int VEC_AMT [NV] = '{0, 5, 7, 8, 15, 16, 100, 255};
  localparam int VEC_EXP [NV] = '{1, 1, 1, 8, 8, 16, 96, 248};

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic fail_i = 1'b0, clear_i = 1'b0, trap_i = 1'b0, wr_valid_i = 1'b0;
  logic [AMT_W-1:0] wr_amount_i = '0;
  logic stall_o, busy_o, done_o;

  int checks = 0, misses = 0;

  always #2 clk_i = ~clk_i;

  backoff_pause_unit #(.LIMIT(LIMIT), .SCALE_SH(SCALE_SH), .TICK_SH(TICK_SH)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .fail_i(fail_i), .clear_i(clear_i),
    .trap_i(trap_i), .wr_valid_i(wr_valid_i), .wr_amount_i(wr_amount_i),
    .stall_o(stall_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic kick(input bit f, input bit w, input int a, input bit c);
    @(negedge clk_i);
    fail_i = f; wr_valid_i = w; wr_amount_i = AMT_W'(a); clear_i = c;
    @(negedge clk_i);
    fail_i = 1'b0; wr_valid_i = 1'b0; clear_i = 1'b0;
  endtask

  task automatic measure(output int n, output int d);
    n = 0;
    while (busy_o && n < 20000) begin
      n++;
      @(negedge clk_i);
    end
    d = int'(done_o);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
    $finish;
  end

  initial begin
    int n, d, n0;
    int exp_seq [7] = '{128, 256, 512, 1024, 2048, 4096, 4096};
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 busy after reset", int'(busy_o), 0);
    chk("R1 stall after reset", int'(stall_o), 0);
    chk("R1 done after reset", int'(done_o), 0);

    // R5 R6 vector table of direct writes
    for (int i = 0; i < NV; i++) begin
      kick(1'b0, 1'b1, VEC_AMT[i], 1'b0);
      measure(n, d);
      chk(VEC_AMT[i] < 8 ? "R6 short write length" : "R5 write length", n, VEC_EXP[i]);
      chk("R9 done at end of write pause", d, 1);
    end
    @(negedge clk_i);
    chk("R9 done lasts one cycle", int'(done_o), 0);

    // R1 R2 R3 doubling from reset weight, capped above LIMIT
    for (int i = 0; i < 7; i++) begin
      kick(1'b1, 1'b0, 0, 1'b0);
      measure(n, d);
      chk(i == 0 ? "R1 first fail length" : (i < 5 ? "R2 doubled length" : "R3 capped length"),
          n, exp_seq[i]);
    end

    // R4 clear resets weight; fail with clear dropped
    kick(1'b0, 1'b0, 0, 1'b1);
    kick(1'b1, 1'b0, 0, 1'b0);
    measure(n, d);
    chk("R4 fail after clear", n, 128);
    kick(1'b1, 1'b0, 0, 1'b1);
    chk("R4 fail with clear starts nothing", int'(busy_o), 0);
    kick(1'b1, 1'b0, 0, 1'b0);
    measure(n, d);
    chk("R4 weight back to 1", n, 128);

    // R7 fail and write ignored mid-pause (weight now 2)
    kick(1'b1, 1'b0, 0, 1'b0);
    n0 = 0;
    repeat (5) begin
      if (busy_o) n0++;
      @(negedge clk_i);
    end
    fail_i = 1'b1; wr_valid_i = 1'b1; wr_amount_i = AMT_W'(8);
    if (busy_o) n0++;
    @(negedge clk_i);
    fail_i = 1'b0; wr_valid_i = 1'b0;
    measure(n, d);
    chk("R7 pause not reloaded", n0 + n, 256);
    kick(1'b1, 1'b0, 0, 1'b0);
    measure(n, d);
    chk("R7 weight unchanged by ignored fail", n, 512);

    // R11 fail beats write
    kick(1'b0, 1'b0, 0, 1'b1);
    kick(1'b1, 1'b1, 8, 1'b0);
    measure(n, d);
    chk("R11 fail wins over write", n, 128);

    // R8 R10 trap abort
    kick(1'b0, 1'b1, 200, 1'b0);
    repeat (10) @(negedge clk_i);
    chk("R10 stall while busy", int'(stall_o), 1);
    trap_i = 1'b1;
    #1;
    chk("R8 stall drops with trap", int'(stall_o), 0);
    chk("R10 busy still high in trap cycle", int'(busy_o), 1);
    @(negedge clk_i);
    trap_i = 1'b0;
    chk("R8 busy cleared after trap", int'(busy_o), 0);
    chk("R9 done after trap", int'(done_o), 1);
    @(negedge clk_i);
    trap_i = 1'b1;
    @(negedge clk_i);
    trap_i = 1'b0;
    chk("R8 idle trap no done", int'(done_o), 0);
    kick(1'b0, 1'b1, 16, 1'b0);
    measure(n, d);
    chk("R8 idle trap leaves next pause intact", n, 16);

    $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
    $finish;
  end
endmodule